// File: doc/BRIEF.md
# Signature-Compare Output Release Gate

This block sits on the checking side of a redundant processor pair. Every output the leading processor produces reaches it as one message. The message carries an execution timestamp, an execution signature that condenses the leader's computation up to that point, the payload, and a flag. The flag marks outputs whose effects can be undone, which the leader has therefore already sent on its own. The gate holds these messages in arrival order. It waits until the local trailing processor reaches the same execution point and presents its own timestamp and signature.

When the timestamp and the signature both agree with the oldest held message, the gate pulses a checkpoint commit. It also hands the payload to the network through a valid/ready port, unless the message was flagged as already sent. When either value differs, nothing is released. The gate pulses a rollback request to both processors and discards every held message. It then refuses new work until the checkpoint restore is reported complete.

Top module: `sig_release_gate`

## Requirements
- R1: After reset `out_valid`, `commit` and `rollback` are 0, `m_ready` is 1 and `s_ready` is 0.
- R2: Master messages are held in an in-order buffer of `DEPTH` entries. `m_ready` is 0 while it is full, and a message is taken on a clock edge with `m_valid` and `m_ready` both 1.
- R3: `s_ready` is 1 only when the buffer holds at least one message, no recovery is in progress and the outbound register is empty. A slave check is taken on an edge with `s_valid` and `s_ready` both 1.
- R4: A taken check whose `s_ts` and `s_fp` both equal the oldest held message is a match. In the following cycle `commit` is 1 for exactly one cycle, and that message leaves the buffer.
- R5: On a match with the message's `m_nofwd` bit at 0, `out_valid` is 1 and `out_data` is that message's payload in the cycle after the check.
- R6: On a match with `m_nofwd` at 1, `commit` pulses but `out_valid` stays 0.
- R7: A taken check that differs from the oldest message in timestamp or in signature causes `rollback` to be 1 for exactly one cycle in the following cycle, with `commit` and `out_valid` both 0.
- R8: After a mismatch every held message is discarded, including one taken on the same edge. `m_ready` and `s_ready` stay 0 until `rb_done` is sampled at 1. After that, messages are accepted again and the buffer is empty.
- R9: Checks are matched against held messages in the order the messages arrived.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold and no check is taken. `out_valid` falls on the edge where `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | 1 | Master message present |
| m_ready | output | 1 | Gate can take a master message |
| m_ts | input | TS_W | Master execution timestamp |
| m_fp | input | FP_W | Master execution signature |
| m_data | input | DATA_W | Output payload |
| m_nofwd | input | 1 | 1: payload already sent by master, compare only |
| s_valid | input | 1 | Slave reached an execution point |
| s_ready | output | 1 | Gate can take a slave check |
| s_ts | input | TS_W | Slave execution timestamp |
| s_fp | input | FP_W | Slave execution signature |
| out_valid | output | 1 | Validated payload on offer |
| out_ready | input | 1 | Network accepts payload |
| out_data | output | DATA_W | Validated payload |
| commit | output | 1 | One-cycle checkpoint commit pulse |
| rollback | output | 1 | One-cycle restore request to both processors |
| rb_done | input | 1 | Checkpoint restore completed |

## Verification
The assertions check, on every cycle, several rules that hold at the ports. A payload may only appear together with a commit pulse. A rollback always finds the buffer empty and nothing on offer. Both input sides stay closed through recovery. A stalled payload does not change. The bench's scenarios are the only proof of the behaviours that depend on values. These are the choice between match and mismatch for timestamp and for signature errors, the suppression of flagged payloads, oldest-first ordering across several held messages, back-pressure at full depth, and the return to service once the restore reports completion.

// File: rtl/sg_pkg.sv
// Shared types for the signature-compare release gate.
// Assumes nothing beyond a 1800-2017 compiler.
package sg_pkg;
    typedef enum logic [0:0] {
        SG_RUN     = 1'b0,
        SG_RECOVER = 1'b1
    } sg_state_e;
endpackage

// File: rtl/sg_fifo.sv
// In-order holding buffer for master messages.
// Assumes push is only issued when not full and pop only when not empty;
// flush empties the buffer and takes priority over push and pop.
module sg_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
    localparam logic [CW-1:0] CDEPTH = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wptr] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CDEPTH);

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/sg_judge.sv
// Decision logic: compares the slave check with the oldest message,
// issues commit or rollback, and tracks recovery until restore completes.
// Assumes chk_fire is only raised while a message is held.
module sg_judge #(
    parameter int TS_W = 16,
    parameter int FP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_fire,
    input  logic [TS_W-1:0] chk_ts,
    input  logic [FP_W-1:0] chk_fp,
    input  logic [TS_W-1:0] ref_ts,
    input  logic [FP_W-1:0] ref_fp,
    input  logic            rb_done,
    output logic            agree,
    output logic            disagree,
    output logic            recovering,
    output logic            commit,
    output logic            rollback
);
    import sg_pkg::*;

    sg_state_e state;
    logic      hit;

    // Both execution point and signature must coincide
    always_comb begin
        hit      = (chk_ts == ref_ts) && (chk_fp == ref_fp);
        agree    = chk_fire && hit;
        disagree = chk_fire && !hit;
    end

    // Outcome pulses and recovery state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SG_RUN;
            commit   <= 1'b0;
            rollback <= 1'b0;
        end else begin
            commit   <= agree;
            rollback <= disagree;
            if (disagree)
                state <= SG_RECOVER;
            else if (state == SG_RECOVER && rb_done)
                state <= SG_RUN;
        end
    end

    assign recovering = (state == SG_RECOVER);

    a_r4_commit_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(chk_fire));
    a_r7_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> !commit && recovering);
endmodule

// File: rtl/sg_egress.sv
// Outbound register with valid/ready hand-off of validated payloads.
// Assumes load is only raised while the register is empty.
module sg_egress #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Hold payload until the network takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= din;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/sig_release_gate.sv
// Signature-compare output release gate for the checking side of a
// redundant pair. Buffers master outputs, compares each against the
// slave's timestamp and signature, releases or withholds the payload and
// drives checkpoint commit or two-sided rollback.
// Assumes the slave presents checks in execution order.
module sig_release_gate #(
    parameter int TS_W   = 16,
    parameter int FP_W   = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_valid,
    output logic              m_ready,
    input  logic [TS_W-1:0]   m_ts,
    input  logic [FP_W-1:0]   m_fp,
    input  logic [DATA_W-1:0] m_data,
    input  logic              m_nofwd,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [TS_W-1:0]   s_ts,
    input  logic [FP_W-1:0]   s_fp,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              commit,
    output logic              rollback,
    input  logic              rb_done
);
    localparam int ENT_W = 1 + TS_W + FP_W + DATA_W;
    localparam int CW    = $clog2(DEPTH+1);

    logic [ENT_W-1:0]  ent_in, ent_head;
    logic              f_empty, f_full;
    logic [CW-1:0]     f_count;
    logic              agree, disagree, recovering;
    logic              m_fire, s_fire;
    logic              h_nofwd;
    logic [TS_W-1:0]   h_ts;
    logic [FP_W-1:0]   h_fp;
    logic [DATA_W-1:0] h_data;

    // Handshake gating on both input sides
    always_comb begin
        m_ready = !f_full && !recovering;
        s_ready = !f_empty && !recovering && !out_valid;
        m_fire  = m_valid && m_ready;
        s_fire  = s_valid && s_ready;
        ent_in  = {m_nofwd, m_ts, m_fp, m_data};
        {h_nofwd, h_ts, h_fp, h_data} = ent_head;
    end

    sg_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(m_fire), .din(ent_in),
        .pop(agree), .flush(disagree),
        .head(ent_head), .empty(f_empty), .full(f_full), .count(f_count)
    );

    sg_judge #(.TS_W(TS_W), .FP_W(FP_W)) u_judge (
        .clk(clk), .rst_n(rst_n),
        .chk_fire(s_fire), .chk_ts(s_ts), .chk_fp(s_fp),
        .ref_ts(h_ts), .ref_fp(h_fp), .rb_done(rb_done),
        .agree(agree), .disagree(disagree), .recovering(recovering),
        .commit(commit), .rollback(rollback)
    );

    sg_egress #(.DATA_W(DATA_W)) u_egress (
        .clk(clk), .rst_n(rst_n),
        .load(agree && !h_nofwd), .din(h_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );

    a_r5_release_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> commit);
    a_r8_flush_on_rollback: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> (f_count == '0) && !out_valid);
    a_r8_closed_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        recovering |-> !m_ready && !s_ready);
endmodule

// File: tb/sim_sig_release_gate.sv
module sim_sig_release_gate;
    localparam int TS_W = 16, FP_W = 32, DATA_W = 32, DEPTH = 4;

    logic clk = 0, rst_n = 0;
    logic m_valid = 0, m_ready, m_nofwd = 0;
    logic [TS_W-1:0] m_ts = 0, s_ts = 0;
    logic [FP_W-1:0] m_fp = 0, s_fp = 0;
    logic [DATA_W-1:0] m_data = 0, out_data;
    logic s_valid = 0, s_ready, out_valid, out_ready = 1;
    logic commit, rollback, rb_done = 0;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    sig_release_gate #(.TS_W(TS_W), .FP_W(FP_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_valid), .m_ready(m_ready), .m_ts(m_ts), .m_fp(m_fp),
        .m_data(m_data), .m_nofwd(m_nofwd),
        .s_valid(s_valid), .s_ready(s_ready), .s_ts(s_ts), .s_fp(s_fp),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .commit(commit), .rollback(rollback), .rb_done(rb_done)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send_m(input logic [15:0] ts, input logic [31:0] fp, input logic [31:0] d, input logic nf);
        m_valid = 1; m_ts = ts; m_fp = fp; m_data = d; m_nofwd = nf;
        @(posedge clk); @(negedge clk);
        m_valid = 0;
    endtask

    task automatic send_s(input logic [15:0] ts, input logic [31:0] fp);
        s_valid = 1; s_ts = ts; s_fp = fp;
        @(posedge clk); @(negedge clk);
        s_valid = 0;
    endtask

    task automatic t_reset;
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(commit == 0 && rollback == 0, "R1 commit/rollback", {commit, rollback}, 0);
        chk(m_ready == 1, "R1 m_ready", m_ready, 1);
        chk(s_ready == 0, "R1 R3 s_ready empty", s_ready, 0);
    endtask

    task automatic t_match_stall;
        out_ready = 0;
        send_m(16'd1, 32'hA1, 32'hD1, 0);
        send_m(16'd2, 32'hA2, 32'hD2, 0);
        send_s(16'd1, 32'hA1);
        chk(commit == 1, "R4 commit", commit, 1);
        chk(out_valid == 1 && out_data == 32'hD1, "R5 release", out_data, 32'hD1);
        @(negedge clk);
        chk(commit == 0, "R4 one-cycle commit", commit, 0);
        chk(out_valid == 1 && out_data == 32'hD1, "R10 hold", out_data, 32'hD1);
        chk(s_ready == 0, "R10 R3 no check while stalled", s_ready, 0);
        out_ready = 1;
        @(negedge clk);
        chk(out_valid == 0, "R10 drained", out_valid, 0);
        send_s(16'd2, 32'hA2);
        chk(out_data == 32'hD2 && commit, "R5 second", out_data, 32'hD2);
    endtask

    task automatic t_nofwd;
        @(negedge clk);
        send_m(16'd3, 32'hB3, 32'hD3, 1);
        send_s(16'd3, 32'hB3);
        chk(commit == 1, "R6 commit", commit, 1);
        chk(out_valid == 0, "R6 no release", out_valid, 0);
    endtask

    task automatic t_order;
        send_m(16'd5, 32'hC5, 32'hE5, 0);
        send_m(16'd6, 32'hC6, 32'hE6, 0);
        send_m(16'd7, 32'hC7, 32'hE7, 0);
        for (int i = 0; i < 3; i++) begin
            send_s(16'(5 + i), 32'hC5 + 32'(i));
            chk(commit && out_valid && out_data == 32'hE5 + 32'(i), "R9 order", out_data, 32'hE5 + 32'(i));
            @(negedge clk);
        end
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) send_m(16'(40 + i), 32'(i), 32'(i), 1);
        chk(m_ready == 0, "R2 full", m_ready, 0);
        send_s(16'd40, 32'd0);
        chk(m_ready == 1, "R2 space after pop", m_ready, 1);
        for (int i = 1; i < DEPTH; i++) send_s(16'(40 + i), 32'(i));
        chk(s_ready == 0, "R3 empty after drain", s_ready, 0);
    endtask

    task automatic t_mismatch;
        send_m(16'd10, 32'hF0, 32'h10, 0);
        send_m(16'd11, 32'hF1, 32'h11, 0);
        send_s(16'd10, 32'hBAD);
        chk(rollback == 1, "R7 rollback", rollback, 1);
        chk(commit == 0 && out_valid == 0, "R7 no commit/release", {commit, out_valid}, 0);
        chk(m_ready == 0 && s_ready == 0, "R8 closed", {m_ready, s_ready}, 0);
        @(negedge clk); @(negedge clk);
        chk(rollback == 0, "R7 one-cycle rollback", rollback, 0);
        chk(m_ready == 0 && s_ready == 0, "R8 still closed", {m_ready, s_ready}, 0);
        rb_done = 1; @(negedge clk); rb_done = 0;
        chk(m_ready == 1, "R8 reopened", m_ready, 1);
        chk(s_ready == 0, "R8 flushed", s_ready, 0);
        send_m(16'd20, 32'h20, 32'h200, 0);
        send_s(16'd20, 32'h20);
        chk(commit && out_data == 32'h200, "R8 resumed", out_data, 32'h200);
        @(negedge clk);
    endtask

    task automatic t_ts_mismatch;
        send_m(16'd30, 32'h30, 32'h300, 0);
        send_s(16'd31, 32'h30);
        chk(rollback == 1 && out_valid == 0, "R7 timestamp mismatch", rollback, 1);
        rb_done = 1; @(negedge clk); rb_done = 0;
        chk(m_ready == 1 && s_ready == 0, "R8 reopen empty", {m_ready, s_ready}, 2'b10);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_match_stall();
        t_nofwd();
        t_order();
        t_full();
        t_mismatch();
        t_ts_mismatch();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule